// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a three-wire stereo PCM stream (bit clock, word clock and one serial data line shared by both channels) into parallel left and right samples. It runs on a system clock that is several times faster than the bit clock. All three serial inputs pass through synchronizers. The rising edges of the bit clock are then found as single-cycle events, and every serial bit, along with the word-clock level, is taken on one of those events.

A two-bit format select chooses one of four framings at run time: I2S, left-justified, right-justified, or a DSP-style frame that starts with a one-bit pulse. A word-length select chooses 16-bit or 18-bit samples. Each completed stereo frame produces one valid strobe, one system clock wide, with the left and right samples of that frame. Samples come out MSB-aligned in an 18-bit field. The format and word-length selects must stay steady while the stream runs; change them only while reset is held.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is high and after it is released, `left_o` and `right_o` are zero and `valid_o` is low until the first frame completes.
- R2: When `fmt_sel` is 2'b01 (I2S), the sample MSB is taken one bit-clock period after each word-clock transition. Word clock low carries the left channel and high carries the right.
- R3: When `fmt_sel` is 2'b10 (left-justified), the sample MSB is the bit taken at the first bit-clock rise after the word-clock change. Word clock high carries left and low carries right.
- R4: When `fmt_sel` is 2'b00 (right-justified), the sample is the last N bits taken before a word-clock transition. Word clock high carries left and low carries right, so the right sample of a frame completes on the next low-to-high transition.
- R5: When `fmt_sel` is 2'b11 (DSP), a low-to-high word-clock change starts a frame. The bit taken with the pulse high is the left MSB. The left sample (N bits, MSB first) is followed at once by the right sample (N bits).
- R6: When `wide_sel` is 1, N = 18 and the sample fills bits 17:0. When `wide_sel` is 0, N = 16, the sample fills bits 17:2, and bits 1:0 are zero.
- R7: Slot bits outside the N sample bits have no effect on the delivered samples.
- R8: `valid_o` is high for exactly one system clock per completed frame, after its right sample is captured. `left_o` and `right_o` change only together with that strobe and hold otherwise.
- R9: Bits are taken only on bit-clock rising edges, and each frame's output follows such an edge. No frame is reported before the first word-clock transition seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| wclk_i | input | 1 | Left/right word clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Frame format: 00 right-justified, 01 I2S, 10 left-justified, 11 DSP |
| wide_sel | input | 1 | Word length: 1 = 18 bits, 0 = 16 bits |
| left_o | output | 18 | Left sample, MSB-aligned |
| right_o | output | 18 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
On every cycle, the assertions check the following:
- the strobe is one cycle wide;
- the output pair holds between strobes;
- each strobe follows a bit-clock rise event, and those events are never adjacent;
- no strobe appears before the receiver has been primed;
- the two low bits are zero in 16-bit mode.

Only the bench scenarios can show the rest:
- that each format puts the right bits into the right channel;
- that padding bits are ignored;
- that the right-justified right sample waits for the next word-clock edge;
- that one strobe appears per frame, and none while the word clock stays still.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_chain
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
  input  logic clk,
  input  logic rst,
  input  logic bclk_s,
  output logic bit_rise
);
  logic bclk_d;

  always_ff @(posedge clk) begin
    if (rst) bclk_d <= 1'b0;
    else     bclk_d <= bclk_s;
  end

  assign bit_rise = bclk_s & ~bclk_d;

  // R9: a rise event never lasts two cycles
  assert_rise_single_R9: assert property (@(posedge clk) disable iff (rst)
    bit_rise |=> !bit_rise);
endmodule

// File: rtl/aud_rx_deframe.sv
module aud_rx_deframe
  import aud_rx_pkg::*;
#(
  parameter int W_LONG  = 18,
  parameter int W_SHORT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_rise,
  input  logic              wsel_s,
  input  logic              sd_s,
  input  fmt_e              fmt,
  input  logic              wide,
  output logic [W_LONG-1:0] left_o,
  output logic [W_LONG-1:0] right_o,
  output logic              valid_o
);
  localparam int CW = $clog2(2 * W_LONG + 2);
  localparam logic [CW-1:0] CMAX = '1;
  localparam int PADW = W_LONG - W_SHORT;

  logic [W_LONG-1:0] sh, sh_n, src, word, lhold;
  logic [CW-1:0]     cnt, cnt_n, nlen, nlen2;
  logic              wprev, seen, wedge, cap_l, cap_r;

  assign nlen  = wide ? CW'(W_LONG) : CW'(W_SHORT);
  assign nlen2 = nlen << 1;
  assign sh_n  = {sh[W_LONG-2:0], sd_s};
  assign wedge = seen && (wsel_s != wprev);

  always_comb begin
    cnt_n = cnt;
    if (fmt == FMT_DSP) begin
      if (wedge && wsel_s)  cnt_n = CW'(1);
      else if (cnt != CMAX) cnt_n = cnt + 1'b1;
    end else if (wedge) begin
      cnt_n = (fmt == FMT_I2S) ? CW'(0) : CW'(1);
    end else if (cnt != CMAX) begin
      cnt_n = cnt + 1'b1;
    end
  end

  always_comb begin
    cap_l = 1'b0;
    cap_r = 1'b0;
    unique case (fmt)
      FMT_RJ: begin
        cap_l = wedge && wprev;
        cap_r = wedge && !wprev;
      end
      FMT_LJ: begin
        cap_l = (cnt_n == nlen) && wsel_s;
        cap_r = (cnt_n == nlen) && !wsel_s;
      end
      FMT_I2S: begin
        cap_l = (cnt_n == nlen) && !wsel_s;
        cap_r = (cnt_n == nlen) && wsel_s;
      end
      FMT_DSP: begin
        cap_l = (cnt_n == nlen);
        cap_r = (cnt_n == nlen2);
      end
      default: ;
    endcase
  end

  // right-justified latches the bits before the edge; others include this bit
  assign src  = (fmt == FMT_RJ) ? sh : sh_n;
  assign word = wide ? src : {src[W_SHORT-1:0], {PADW{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      cnt     <= CMAX;
      wprev   <= 1'b0;
      seen    <= 1'b0;
      lhold   <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_rise) begin
        sh    <= sh_n;
        cnt   <= cnt_n;
        wprev <= wsel_s;
        seen  <= 1'b1;
        if (cap_l) lhold <= word;
        if (cap_r) begin
          left_o  <= lhold;
          right_o <= word;
          valid_o <= 1'b1;
        end
      end
    end
  end

  assert_valid_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
  assert_valid_after_rise_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(bit_rise));
  assert_primed_before_out_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> seen);
  assert_short_pad_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !wide) |-> (left_o[PADW-1:0] == '0 && right_o[PADW-1:0] == '0));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int W_LONG      = 18,
  parameter int W_SHORT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  input  logic [1:0]        fmt_sel,
  input  logic              wide_sel,
  output logic [W_LONG-1:0] left_o,
  output logic [W_LONG-1:0] right_o,
  output logic              valid_o
);
  logic [2:0] raw, synced;
  logic       bit_rise;

  assign raw = {sdata_i, wclk_i, bclk_i};

  aud_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) i_sync (
    .clk (clk),
    .rst (rst),
    .din (raw),
    .dout(synced)
  );

  aud_rx_edge i_edge (
    .clk     (clk),
    .rst     (rst),
    .bclk_s  (synced[0]),
    .bit_rise(bit_rise)
  );

  aud_rx_deframe #(.W_LONG(W_LONG), .W_SHORT(W_SHORT)) i_deframe (
    .clk     (clk),
    .rst     (rst),
    .bit_rise(bit_rise),
    .wsel_s  (synced[1]),
    .sd_s    (synced[2]),
    .fmt     (fmt_e'(fmt_sel)),
    .wide    (wide_sel),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
  );
endmodule

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int SLOT       = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_i = 1'b0, wclk_i = 1'b0, sdata_i = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        wide_sel = 1'b0;
  logic [17:0] left_o, right_o;
  logic        valid_o;

  int checks = 0, fails = 0, wr = 0, rd = 0, cycles = 0;
  logic [17:0] exp_l [64];
  logic [17:0] exp_r [64];
  string tag = "R1";

  audio_serial_rx i_audio_serial_rx (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .wclk_i(wclk_i), .sdata_i(sdata_i),
    .fmt_sel(fmt_sel), .wide_sel(wide_sel),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [17:0] aligned(input logic [17:0] v, input logic wide);
    return wide ? v : (v << 2);
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: got %0d cycles exp at most 150000", cycles);
        summary();
      end
    end
  end

  // output monitor: compare each strobe with the expected queue
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      checks++;
      if (rd >= wr) begin
        fails++;
        $display("FAIL %s/R8: unexpected strobe got %h/%h exp none", tag, left_o, right_o);
      end else begin
        if (left_o !== exp_l[rd] || right_o !== exp_r[rd]) begin
          fails++;
          $display("FAIL %s/R6/R7: got %h/%h exp %h/%h", tag, left_o, right_o,
                   exp_l[rd], exp_r[rd]);
        end
        rd++;
      end
    end
  end

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk);
    bclk_i = 1'b0; wclk_i = w; sdata_i = d;
    repeat (HALF_BIT) @(negedge clk);
    bclk_i = 1'b1;
    repeat (HALF_BIT) @(negedge clk);
  endtask

  task automatic send_half(input logic [1:0] f, input int n, input logic lvl,
                           input logic [17:0] v);
    for (int i = 0; i < SLOT; i++) begin
      logic d;
      d = 1'($urandom);
      if (f == 2'b10 && i < n)                  d = v[n-1-i];
      if (f == 2'b01 && i >= 1 && i <= n)       d = v[n-i];
      if (f == 2'b00 && i >= SLOT - n)          d = v[SLOT-1-i];
      send_bit(lvl, d);
    end
  endtask

  task automatic send_frame(input logic [1:0] f, input logic wide,
                            input logic [17:0] l, input logic [17:0] r);
    int n;
    n = wide ? 18 : 16;
    exp_l[wr] = aligned(l, wide);
    exp_r[wr] = aligned(r, wide);
    wr++;
    if (f == 2'b11) begin
      for (int i = 0; i < 2 * SLOT; i++) begin
        logic d;
        d = 1'($urandom);
        if (i < n)          d = l[n-1-i];
        else if (i < 2 * n) d = r[2*n-1-i];
        send_bit(i == 0, d);
      end
    end else begin
      send_half(f, n, f != 2'b01, l);
      send_half(f, n, f == 2'b01, r);
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic wide);
    rst = 1'b1;
    fmt_sel = f; wide_sel = wide;
    bclk_i = 1'b0; wclk_i = 1'b0; sdata_i = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wr = 0; rd = 0;
  endtask

  task automatic check_count(input string rq);
    repeat (40) @(negedge clk);
    checks++;
    if (rd != wr) begin
      fails++;
      $display("FAIL %s: strobe count got %0d exp %0d", rq, rd, wr);
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    // R1: reset state
    do_reset(2'b10, 1'b1);
    @(negedge clk);
    checks++;
    if (left_o !== 18'd0 || right_o !== 18'd0 || valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: got %h/%h/%b exp 0/0/0", left_o, right_o, valid_o);
    end

    // R9: bits without any word-clock edge give no strobe
    tag = "R9";
    for (int i = 0; i < 48; i++) send_bit(1'b0, 1'($urandom));
    check_count("R9");

    for (int fi = 0; fi < 4; fi++) begin
      for (int wi = 0; wi < 2; wi++) begin
        logic [1:0] f;
        logic       wide;
        logic [17:0] mask;
        int nf;
        f = 2'(fi);
        wide = 1'(wi);
        mask = wide ? 18'h3FFFF : 18'h0FFFF;
        case (f)
          2'b00: tag = "R4";
          2'b01: tag = "R2";
          2'b10: tag = "R3";
          default: tag = "R5";
        endcase
        do_reset(f, wide);
        // prelude: opposite (or same, for R4) level so the frame starts on an edge
        for (int i = 0; i < 4; i++) send_bit(f == 2'b01 || f == 2'b00, 1'($urandom));
        // directed corners: full scale, single LSB, single MSB
        send_frame(f, wide, mask, 18'd0);
        send_frame(f, wide, 18'd1, mask & ~(mask >> 1));
        nf = 3 + int'($urandom % 3);
        for (int k = 0; k < nf; k++)
          send_frame(f, wide, 18'($urandom) & mask, 18'($urandom) & mask);
        // flush: R4 needs the closing low-to-high edge for its last right sample
        for (int i = 0; i < 4; i++) send_bit(f != 2'b11 && f != 2'b01, 1'($urandom));
        check_count({tag, "/R8"});
      end
    end

    // R1 again: reset clears a populated output
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (left_o !== 18'd0 || right_o !== 18'd0 || valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: got %h/%h/%b exp 0/0/0", left_o, right_o, valid_o);
    end
    summary();
  end
endmodule